// File: doc/BRIEF.md
# In-Flight Memory Address Gate

This block keeps, for each hardware thread of an in-order pipeline, a small table of the memory addresses that currently have an access outstanding. Before a memory stage issues an access, it presents the thread id, the address, the requesting instruction's sequence number and a flag that says whether the access comes from the instruction-fetch port. The gate answers in the same cycle with a grant or, by leaving grant low, a deny. A granted new access claims an entry that holds the address and its owner sequence number.

Data accesses to an address that is already busy are refused unless the requester is the instruction that owns the entry. That exception lets a replayed access enter again. Fetch-port accesses skip the address comparison and need only a free entry. A thread whose address translation is stalled on a fault has every request refused. When an access finishes or is squashed, a remove command names the thread and the address, and the matching entry is released. Each thread's table drives a full flag.

Top module: `inflight_addr_gate`

## Requirements
- R1: A data request (`req_ifetch`=0) from a thread that is not held, whose address matches no entry of that thread, is granted in the same cycle when a free entry exists. The lowest-numbered free entry then records the address and the sequence number.
- R2: A data request whose address matches an entry of its thread with an equal sequence number is granted and claims no further entry.
- R3: A data request whose address matches entries of its thread only with other sequence numbers is denied, and the table is left unchanged.
- R4: A fetch-port request (`req_ifetch`=1) is granted whenever its thread has a free entry, whatever the addresses stored. It then claims the lowest-numbered free entry, even for an address that is already present. When the thread has no free entry, it is denied.
- R5: A remove (`rm_valid`=1) clears the lowest-numbered valid entry of thread `rm_tid` whose address equals `rm_addr`. After that, a request from another owner for that address is no longer blocked by that entry.
- R6: Tables of different threads are independent: the entries of one thread never cause a grant or a deny for another thread.
- R7: While `xlat_hold[t]` is 1, every request of thread t is denied and leaves the table unchanged.
- R8: `tbl_full[t]` is 1 exactly when all entries of thread t are valid. A data request for a new address to a full thread is denied.
- R9: When a remove and a request for the same thread arrive in one cycle, the remove is applied first, and the request is decided against the table without the removed entry.
- R10: A remove for an address that is absent from the thread's table changes nothing.
- R11: After reset, all tables are empty, every `tbl_full` bit is 0, and `req_grant` is 0.
- R12: With `req_valid`=0, `req_grant` is 0 and no entry is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_tid | input | TID_W | Requesting thread |
| req_addr | input | ADDR_W | Requested address |
| req_seq | input | SEQ_W | Sequence number of the requester |
| req_ifetch | input | 1 | 1 = fetch-port request, 0 = data request |
| xlat_hold | input | THREADS | Per-thread translation-fault hold |
| req_grant | output | 1 | Request accepted (combinational) |
| rm_valid | input | 1 | Release an entry this cycle |
| rm_tid | input | TID_W | Thread of the release |
| rm_addr | input | ADDR_W | Address to release |
| tbl_full | output | THREADS | Per-thread table-full flag |

## Verification
The bench builds the gate with two threads, four entries per thread, a 3-bit address and a 2-bit sequence number. With these values, filling a table, producing duplicate fetch entries, making owner collisions and hitting removes that coincide with requests all take only a handful of cycles. A long random sweep over this small space reaches every decision path many times: full tables, replays, held threads and removes of absent addresses. Directed sequences then fix the same-cycle remove ordering and the isolation between threads.

// File: rtl/aht_pkg.sv
package aht_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE   = 2'd0,
      ACT_INSERT = 2'd1,
      ACT_REPLAY = 2'd2,
      ACT_DENY   = 2'd3
   } aht_act_e;
endpackage

// File: rtl/aht_prio_pick.sv
module aht_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] vec,
   output logic [N-1:0] onehot,
   output logic         any
);
   always_comb begin
      logic seen;
      seen   = 1'b0;
      onehot = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i] && !seen) begin
            onehot[i] = 1'b1;
            seen      = 1'b1;
         end
      end
   end
   assign any = |vec;
endmodule

// File: rtl/aht_thread_bank.sv
module aht_thread_bank
   import aht_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   parameter int SEQ_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rm_en,
   input  logic [ADDR_W-1:0] rm_addr,
   input  logic              rq_en,
   input  logic [ADDR_W-1:0] rq_addr,
   input  logic [SEQ_W-1:0]  rq_seq,
   input  logic              rq_ifetch,
   input  logic              rq_blocked,
   output logic              rq_grant,
   output logic              bank_full
);
   logic [ENTRIES-1:0] vld_q;
   logic [ADDR_W-1:0]  addr_q [ENTRIES];
   logic [SEQ_W-1:0]   seq_q  [ENTRIES];

   logic [ENTRIES-1:0] rm_match, rm_1h, kept;
   logic [ENTRIES-1:0] rq_hit, rq_own, ins_1h;
   logic               rm_any, has_free;
   aht_act_e           act;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign rm_match[e] = vld_q[e] && (addr_q[e] == rm_addr);
      assign rq_hit[e]   = kept[e] && (addr_q[e] == rq_addr);
      assign rq_own[e]   = rq_hit[e] && (seq_q[e] == rq_seq);
   end

   aht_prio_pick #(.N(ENTRIES)) u_rm_pick (
      .vec(rm_match), .onehot(rm_1h), .any(rm_any)
   );

   // removal is applied before the request is decided
   assign kept = vld_q & ~(rm_en ? rm_1h : '0);

   aht_prio_pick #(.N(ENTRIES)) u_free_pick (
      .vec(~kept), .onehot(ins_1h), .any(has_free)
   );

   always_comb begin
      act = ACT_IDLE;
      if (rq_en) begin
         if (rq_blocked)        act = ACT_DENY;
         else if (rq_ifetch)    act = has_free ? ACT_INSERT : ACT_DENY;
         else if (|rq_own)      act = ACT_REPLAY;
         else if (|rq_hit)      act = ACT_DENY;
         else if (has_free)     act = ACT_INSERT;
         else                   act = ACT_DENY;
      end
   end

   assign rq_grant  = (act == ACT_INSERT) || (act == ACT_REPLAY);
   assign bank_full = &vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            addr_q[e] <= '0;
            seq_q[e]  <= '0;
         end
      end else begin
         vld_q <= kept | ((act == ACT_INSERT) ? ins_1h : '0);
         for (int e = 0; e < ENTRIES; e++) begin
            if ((act == ACT_INSERT) && ins_1h[e]) begin
               addr_q[e] <= rq_addr;
               seq_q[e]  <= rq_seq;
            end
         end
      end
   end

   logic unused_rm_any;
   assign unused_rm_any = rm_any;
endmodule

// File: rtl/inflight_addr_gate.sv
module inflight_addr_gate #(
   parameter int THREADS = 4,
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   parameter int SEQ_W   = 16,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [TID_W-1:0]   req_tid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [SEQ_W-1:0]   req_seq,
   input  logic               req_ifetch,
   input  logic [THREADS-1:0] xlat_hold,
   output logic               req_grant,
   input  logic               rm_valid,
   input  logic [TID_W-1:0]   rm_tid,
   input  logic [ADDR_W-1:0]  rm_addr,
   output logic [THREADS-1:0] tbl_full
);
   if (THREADS < 1) begin : g_bad_threads
      $error("THREADS must be at least 1");
   end
   if (ENTRIES < 1) begin : g_bad_entries
      $error("ENTRIES must be at least 1");
   end
   if (ADDR_W < 1 || SEQ_W < 1) begin : g_bad_width
      $error("ADDR_W and SEQ_W must be at least 1");
   end

   logic [THREADS-1:0] sel_rq, sel_rm, bank_grant;

   if (THREADS == 1) begin : g_single
      assign sel_rq[0] = req_valid;
      assign sel_rm[0] = rm_valid;
      logic unused_tids;
      assign unused_tids = ^{req_tid, rm_tid};
   end else begin : g_multi
      for (genvar t = 0; t < THREADS; t++) begin : g_sel
         assign sel_rq[t] = req_valid && (req_tid == TID_W'(t));
         assign sel_rm[t] = rm_valid && (rm_tid == TID_W'(t));
      end
   end

   for (genvar t = 0; t < THREADS; t++) begin : g_bank
      aht_thread_bank #(
         .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .rm_en     (sel_rm[t]),
         .rm_addr   (rm_addr),
         .rq_en     (sel_rq[t]),
         .rq_addr   (req_addr),
         .rq_seq    (req_seq),
         .rq_ifetch (req_ifetch),
         .rq_blocked(xlat_hold[t]),
         .rq_grant  (bank_grant[t]),
         .bank_full (tbl_full[t])
      );
   end

   assign req_grant = |bank_grant;
endmodule

// File: rtl/aht_checker.sv
module aht_checker #(
   parameter int THREADS = 4,
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   parameter int SEQ_W   = 16,
   localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [TID_W-1:0]   req_tid,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [SEQ_W-1:0]   req_seq,
   input logic               req_ifetch,
   input logic [THREADS-1:0] xlat_hold,
   input logic               req_grant,
   input logic               rm_valid,
   input logic [TID_W-1:0]   rm_tid,
   input logic [ADDR_W-1:0]  rm_addr,
   input logic [THREADS-1:0] tbl_full
);
   p_idle_no_grant_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !req_grant);

   // R3: a refusal with no remove never changes any table's fullness
   p_deny_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_grant && !rm_valid) |=> $stable(tbl_full));

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      p_fill_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(tbl_full[t]) |-> $past(req_valid && req_grant && (req_tid == TID_W'(t))));

      p_drain_needs_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(tbl_full[t]) |-> $past(rm_valid && (rm_tid == TID_W'(t))));

      p_hold_denies_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && (req_tid == TID_W'(t)) && xlat_hold[t]) |-> !req_grant);

      p_full_fetch_denied_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && (req_tid == TID_W'(t)) && req_ifetch && tbl_full[t]
          && !(rm_valid && (rm_tid == TID_W'(t)))) |-> !req_grant);
   end

   logic unused_chk;
   assign unused_chk = ^{req_addr, req_seq, rm_addr};
endmodule

bind inflight_addr_gate aht_checker #(
   .THREADS(THREADS), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
) u_aht_chk (.*);

// File: tb/tb_inflight_addr_gate.sv
`timescale 1ns/1ps
module tb_inflight_addr_gate;
   localparam int TH = 2, EN = 4, AW = 3, SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_ifetch = 0, rm_valid = 0;
   logic [0:0] req_tid = 0, rm_tid = 0;
   logic [AW-1:0] req_addr = 0, rm_addr = 0;
   logic [SW-1:0] req_seq = 0;
   logic [TH-1:0] xlat_hold = 0, tbl_full;
   logic req_grant;

   always #2.5 clk = ~clk;

   inflight_addr_gate #(.THREADS(TH), .ENTRIES(EN), .ADDR_W(AW), .SEQ_W(SW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
      .req_addr(req_addr), .req_seq(req_seq), .req_ifetch(req_ifetch),
      .xlat_hold(xlat_hold), .req_grant(req_grant), .rm_valid(rm_valid),
      .rm_tid(rm_tid), .rm_addr(rm_addr), .tbl_full(tbl_full)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   bit            mv [TH][EN];
   bit [AW-1:0]   ma [TH][EN];
   bit [SW-1:0]   ms [TH][EN];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input bit tid, input bit [AW-1:0] a, input bit [SW-1:0] s,
                       input bit ifx, input bit [TH-1:0] hold, input bit rv, input bit rt,
                       input bit [AW-1:0] ra, input string tag);
      bit kv [EN];
      bit hit, own, exp, ins;
      int re, fr;
      string lab;
      @(negedge clk);
      req_valid = v; req_tid = tid; req_addr = a; req_seq = s; req_ifetch = ifx;
      xlat_hold = hold; rm_valid = rv; rm_tid = rt; rm_addr = ra;
      #1;
      for (int t = 0; t < TH; t++) begin
         bit f;
         f = 1;
         for (int e = 0; e < EN; e++) f &= mv[t][e];
         chk("R8", "tbl_full", int'(tbl_full[t]), int'(f));
      end
      for (int e = 0; e < EN; e++) kv[e] = mv[tid][e];
      re = -1;
      if (rv && rt == tid)
         for (int e = 0; e < EN; e++) if (re < 0 && mv[tid][e] && ma[tid][e] == ra) re = e;
      if (re >= 0) kv[re] = 0;
      hit = 0; own = 0; fr = -1;
      for (int e = 0; e < EN; e++) begin
         if (kv[e] && ma[tid][e] == a) begin
            hit = 1;
            if (ms[tid][e] == s) own = 1;
         end
         if (!kv[e] && fr < 0) fr = e;
      end
      ins = 0;
      if (!v)               begin exp = 0; lab = "R12"; end
      else if (hold[tid])   begin exp = 0; lab = "R7"; end
      else if (ifx)         begin exp = (fr >= 0); ins = exp; lab = "R4"; end
      else if (own)         begin exp = 1; lab = "R2"; end
      else if (hit)         begin exp = 0; lab = "R3"; end
      else if (fr < 0)      begin exp = 0; lab = "R8"; end
      else                  begin exp = 1; ins = 1; lab = "R1"; end
      if (tag != "") lab = tag;
      chk(lab, "req_grant", int'(req_grant), int'(exp));
      // model update: remove (R5/R10) then insert
      if (rv) begin
         int r2;
         r2 = -1;
         for (int e = 0; e < EN; e++) if (r2 < 0 && mv[rt][e] && ma[rt][e] == ra) r2 = e;
         if (r2 >= 0) mv[rt][r2] = 0;
      end
      if (ins) begin
         mv[tid][fr] = 1; ma[tid][fr] = a; ms[tid][fr] = s;
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int t = 0; t < TH; t++) for (int e = 0; e < EN; e++) mv[t][e] = 0;
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "tbl_full after reset", int'(tbl_full), 0);
      chk("R11", "req_grant after reset", int'(req_grant), 0);
      @(negedge clk) rst_n = 1;

      // R1 / R3 / R2: claim, foreign collision, replay
      step(1, 0, 3'd1, 2'd1, 0, 2'b00, 0, 0, 0, "R1");
      step(1, 0, 3'd1, 2'd2, 0, 2'b00, 0, 0, 0, "R3");
      step(1, 0, 3'd1, 2'd1, 0, 2'b00, 0, 0, 0, "R2");
      // R6: other thread, same address, other owner
      step(1, 1, 3'd1, 2'd3, 0, 2'b00, 0, 0, 0, "R6");
      // R4: fetch duplicate on busy address
      step(1, 0, 3'd1, 2'd3, 1, 2'b00, 0, 0, 0, "R4");
      // R7: held thread
      step(1, 0, 3'd5, 2'd0, 0, 2'b01, 0, 0, 0, "R7");
      step(1, 0, 3'd2, 2'd0, 0, 2'b00, 0, 0, 0, "R1");
      step(1, 0, 3'd3, 2'd0, 0, 2'b00, 0, 0, 0, "R1");
      // thread 0 now full: R8 new address, R4 fetch both denied
      step(1, 0, 3'd6, 2'd0, 0, 2'b00, 0, 0, 0, "R8");
      step(1, 0, 3'd6, 2'd0, 1, 2'b00, 0, 0, 0, "R4");
      // R10: absent remove leaves it full
      step(1, 0, 3'd6, 2'd0, 0, 2'b00, 1, 0, 3'd7, "R10");
      step(0, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R10");
      // R9: same-cycle remove of addr 2 lets new addr 6 in
      step(1, 0, 3'd6, 2'd2, 0, 2'b00, 1, 0, 3'd2, "R9");
      // R5: remove lowest addr-1 entry (owner seq 1), fetch duplicate seq 3 remains
      step(0, 0, 0, 0, 0, 2'b00, 1, 0, 3'd1, "R5");
      step(1, 0, 3'd1, 2'd3, 0, 2'b00, 0, 0, 0, "R5");
      step(1, 0, 3'd1, 2'd1, 0, 2'b00, 0, 0, 0, "R5");

      // random sweep over the small space
      for (int i = 0; i < 6000; i++) begin
         bit [TH-1:0] h;
         h = (($urandom % 8) == 0) ? TH'($urandom) : '0;
         step(($urandom % 4) != 0, 1'($urandom), AW'($urandom % 5), SW'($urandom),
              ($urandom % 5) == 0, h, ($urandom % 2) == 0, 1'($urandom),
              AW'($urandom % 6), "");
      end
      step(0, 0, 0, 0, 0, 2'b00, 0, 0, 0, "R12");
      done = 1;
      summary();
      $finish;
   end
endmodule